// File: doc/BRIEF.md
# Configuration Bitstream Loader Sequencer

This block loads a configuration image into a programmable-logic device through a 16-bit configuration port, with no software in the loop. A byte stream of known total length arrives over a valid/ready handshake. The sequencer first looks for the two-byte start pattern and drops every byte ahead of it. It checks that the bytes from the pattern onward form whole words, and it checks that the board's configuration memory is fitted. It then runs load attempts, up to a fixed number of them. Each attempt resets the local bus, reloads the bridge settings from the memory, and pulses the program pin. It then waits for the device's INIT flag and pushes the image one word at a time, each word gated on the TXREADY flag. When all words are sent, it waits for DONE.

The source must be replayable: the block raises `src_rewind` for one cycle when a load begins and again at the start of every attempt's data phase, and the source must then deliver byte 0 next. Flags are sampled on a prescaled poll tick, so every timeout is a count of polls rather than of clock cycles. The result stays on `done` or `error` with a cause code until the next `start`.

Top module: `bitload_ctrl`

## Requirements
- R1: Bytes ahead of the first 0xFF that is immediately followed by 0x20 are discarded. The first word sent to the port is therefore 0xFF20. The search handles a repeated 0xFF before the pattern, and a pattern in the last two bytes.
- R2: If the stream holds no such pair, including a total length below 2, the load ends with `error` and `err_code` = 1. No reset, reload or program pulse is issued.
- R3: If the byte count from the 0xFF of the pattern to the end of the stream is odd, the load ends with `err_code` = 2 and no pulses.
- R4: If `eeprom_present` is low once the stream checks have passed, the load ends at once with `err_code` = 3 and no pulses.
- R5: Each word sent on `cfg_data` takes the earlier of two consecutive bytes in bits 15:8 and the later one in bits 7:0. Words are sent in stream order.
- R6: Each attempt issues, in order: a `bus_reset` pulse, an `eeprom_reload` low-high-low sequence, then a `prog_pulse`. Every phase lasts PULSE_CYC cycles. If INIT is not seen within INIT_POLLS polls after the program pulse, the attempt fails with code 4.
- R7: `cfg_wr` is raised only after a poll has seen `stat_txready` high. If TXREADY_POLLS polls pass without it, the attempt fails with code 5.
- R8: `stat_init` is checked in the cycle after every `cfg_wr`. If it is low, the attempt fails with code 6.
- R9: After the last word, `fpga_done` must be seen within DONE_POLLS polls, or the attempt fails with code 7. On success, a closing `bus_reset` pulse and reload sequence are issued, and then `done` rises.
- R10: A failed attempt starts a new one from the reset pulse, with `src_rewind` again, up to MAX_TRIES attempts in all. After the last attempt fails, `error` reports that attempt's cause. A later attempt that passes gives `done`.
- R11: After reset, and while idle, `busy`, `done`, `error` and every strobe are low. `done` and `error` are never high together and hold until the next `start`. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (taken when not busy) |
| total_len | input | LEN_W | Total byte count of the stream |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| src_rewind | output | 1 | Source must restart from byte 0 |
| eeprom_present | input | 1 | Configuration memory fitted |
| stat_init | input | 1 | Device INIT flag |
| stat_txready | input | 1 | Port ready for a word |
| fpga_done | input | 1 | Device configured |
| cfg_data | output | 16 | Configuration word |
| cfg_wr | output | 1 | Word write strobe |
| bus_reset | output | 1 | Local-bus reset pulse |
| eeprom_reload | output | 1 | Bridge reload pulse |
| prog_pulse | output | 1 | Program-pin pulse |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load succeeded |
| error | output | 1 | Load failed |
| err_code | output | 3 | Failure cause (0 none, 1 no pattern, 2 odd length, 3 no memory, 4 INIT wait, 5 TXREADY wait, 6 INIT lost, 7 DONE wait) |

## Verification
The assertions rely on three things about the inputs. `total_len` and the stream contents stay fixed for the whole of a load. After each `src_rewind` the source returns to byte 0. The device flags change only between clock edges. The bench model honours all three: it drives every input on the falling edge, holds the length for the whole load, and restarts its byte pointer on every rewind. It makes INIT fall on the program pulse and rise once the pulse ends, toggles TXREADY at random but never holds it low for long in an attempt meant to pass, and raises DONE once the expected word count has arrived. Failure kinds are injected only into selected attempts.

// File: rtl/bitload_pkg.sv
// Shared types of the bitstream loader: sequencer states and failure causes.
package bitload_pkg;
    typedef enum logic [4:0] {
        S_IDLE, S_BEGIN, S_SCAN, S_CHECK,
        S_RST, S_RLD_LO1, S_RLD_HI, S_RLD_LO2, S_PROG_HI, S_PROG_LO,
        S_WAIT_INIT, S_REWIND, S_SKIP, S_GET_HI, S_GET_LO,
        S_WAIT_TX, S_WRITE, S_CHK_INIT, S_WAIT_DONE, S_PASS, S_FAIL
    } ld_state_t;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_NO_MARKER = 3'd1,
        E_ODD_LEN   = 3'd2,
        E_NO_EEPROM = 3'd3,
        E_INIT_TO   = 3'd4,
        E_TXRDY_TO  = 3'd5,
        E_INIT_LOST = 3'd6,
        E_DONE_TO   = 3'd7
    } ld_err_t;
endpackage

// File: rtl/bitload_tick.sv
// Poll prescaler: one-cycle tick every DIV clocks, free running after reset.
// Assumes DIV >= 1.
module bitload_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Count cycles between poll ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/bitload_marker.sv
// Start-pattern detector: flags a 0x20 byte that directly follows a 0xFF.
// Assumes byte_en marks accepted stream bytes; clr restarts the search.
module bitload_marker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       byte_en,
    input  logic [7:0] byte_in,
    output logic       hit
);
    logic prev_ff;

    // Remember whether the last accepted byte was 0xFF.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) prev_ff <= 1'b0;
        else if (byte_en)  prev_ff <= (byte_in == 8'hFF);
    end

    assign hit = prev_ff && (byte_in == 8'h20);
endmodule

// File: rtl/bitload_packer.sv
// Byte-to-word packer: first byte lands in bits 15:8, second in bits 7:0.
// The word register holds steady until the next pair completes.
module bitload_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_hi,
    input  logic        load_lo,
    input  logic [7:0]  byte_in,
    output logic [15:0] word
);
    logic [7:0] hi_q;

    // Capture the upper byte, then form the word on the lower byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            word <= '0;
        end else begin
            if (load_hi) hi_q <= byte_in;
            if (load_lo) word <= {hi_q, byte_in};
        end
    end
endmodule

// File: rtl/bitload_ctrl.sv
// Bitstream loader sequencer. Scans for the 0xFF,0x20 start pattern, checks
// the remaining length is even and the configuration memory is fitted, then
// runs up to MAX_TRIES attempts of reset / reload / program pulse, INIT wait,
// word transfer gated on TXREADY with an INIT check after every write, and a
// DONE wait. Assumes total_len and stream contents are stable during a load
// and that the source restarts at byte 0 after src_rewind.
module bitload_ctrl
    import bitload_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int POLL_DIV    = 100,
    parameter int PULSE_CYC   = 1000,
    parameter int INIT_POLLS  = 50,
    parameter int TXRDY_POLLS = 100,
    parameter int DONE_POLLS  = 200,
    parameter int MAX_TRIES   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             src_rewind,
    input  logic             eeprom_present,
    input  logic             stat_init,
    input  logic             stat_txready,
    input  logic             fpga_done,
    output logic [15:0]      cfg_data,
    output logic             cfg_wr,
    output logic             bus_reset,
    output logic             eeprom_reload,
    output logic             prog_pulse,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [2:0]       err_code
);
    localparam int MAXP0 = (INIT_POLLS > TXRDY_POLLS) ? INIT_POLLS : TXRDY_POLLS;
    localparam int MAXP  = (MAXP0 > DONE_POLLS) ? MAXP0 : DONE_POLLS;
    localparam int PW    = $clog2(MAXP + 1);
    localparam int TW    = $clog2(PULSE_CYC + 1);
    localparam int RW    = $clog2(MAX_TRIES + 1);

    ld_state_t        state;
    ld_err_t          err_q, att_code;
    logic [LEN_W-1:0] cnt, len_q, off_q;
    logic [PW-1:0]    poll;
    logic [TW-1:0]    tmr;
    logic [RW-1:0]    tries;
    logic             fin_q, tick, take, mk_hit, att_fail, is_pulse;

    bitload_tick #(.DIV(POLL_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    bitload_marker u_marker (
        .clk(clk), .rst_n(rst_n), .clr(state == S_BEGIN),
        .byte_en(take && state == S_SCAN), .byte_in(in_data), .hit(mk_hit)
    );

    bitload_packer u_packer (
        .clk(clk), .rst_n(rst_n),
        .load_hi(take && state == S_GET_HI), .load_lo(take && state == S_GET_LO),
        .byte_in(in_data), .word(cfg_data)
    );

    // Successor of each timed pulse phase; the closing sequence ends in PASS.
    function automatic ld_state_t pulse_next(input ld_state_t s, input logic fin);
        case (s)
            S_RST:     return S_RLD_LO1;
            S_RLD_LO1: return S_RLD_HI;
            S_RLD_HI:  return S_RLD_LO2;
            S_RLD_LO2: return fin ? S_PASS : S_PROG_HI;
            S_PROG_HI: return S_PROG_LO;
            default:   return S_WAIT_INIT;
        endcase
    endfunction

    // Stream handshake and pulse-phase decode.
    always_comb begin
        in_ready = state inside {S_SCAN, S_SKIP, S_GET_HI, S_GET_LO};
        take     = in_ready && in_valid;
        is_pulse = state inside {S_RST, S_RLD_LO1, S_RLD_HI, S_RLD_LO2, S_PROG_HI, S_PROG_LO};
    end

    // Detect a failed attempt and its cause.
    always_comb begin
        att_fail = 1'b0;
        att_code = E_NONE;
        case (state)
            S_WAIT_INIT: if (tick && !stat_init && poll == PW'(INIT_POLLS - 1)) begin
                att_fail = 1'b1; att_code = E_INIT_TO;
            end
            S_WAIT_TX: if (tick && !stat_txready && poll == PW'(TXRDY_POLLS - 1)) begin
                att_fail = 1'b1; att_code = E_TXRDY_TO;
            end
            S_CHK_INIT: if (!stat_init) begin
                att_fail = 1'b1; att_code = E_INIT_LOST;
            end
            S_WAIT_DONE: if (tick && !fpga_done && poll == PW'(DONE_POLLS - 1)) begin
                att_fail = 1'b1; att_code = E_DONE_TO;
            end
            default: ;
        endcase
    end

    // Main load sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            err_q <= E_NONE;
            cnt   <= '0;
            len_q <= '0;
            off_q <= '0;
            poll  <= '0;
            tmr   <= '0;
            tries <= '0;
            fin_q <= 1'b0;
        end else begin
            poll <= '0;
            tmr  <= '0;
            if (is_pulse) begin
                if (tmr == TW'(PULSE_CYC - 1)) state <= pulse_next(state, fin_q);
                else                           tmr   <= tmr + 1'b1;
            end
            case (state)
                S_IDLE, S_PASS, S_FAIL: if (start) begin
                    len_q <= total_len;
                    err_q <= E_NONE;
                    state <= S_BEGIN;
                end
                S_BEGIN: begin
                    cnt <= '0;
                    if (len_q < LEN_W'(2)) begin
                        err_q <= E_NO_MARKER;
                        state <= S_FAIL;
                    end else state <= S_SCAN;
                end
                S_SCAN: if (take) begin
                    cnt <= cnt + 1'b1;
                    if (mk_hit) begin
                        off_q <= cnt - 1'b1;
                        state <= S_CHECK;
                    end else if (cnt == len_q - 1'b1) begin
                        err_q <= E_NO_MARKER;
                        state <= S_FAIL;
                    end
                end
                S_CHECK: begin
                    if (len_q[0] ^ off_q[0]) begin
                        err_q <= E_ODD_LEN;
                        state <= S_FAIL;
                    end else if (!eeprom_present) begin
                        err_q <= E_NO_EEPROM;
                        state <= S_FAIL;
                    end else begin
                        tries <= '0;
                        fin_q <= 1'b0;
                        state <= S_RST;
                    end
                end
                S_WAIT_INIT: begin
                    poll <= poll;
                    if (tick) begin
                        if (stat_init) state <= S_REWIND;
                        else           poll  <= poll + 1'b1;
                    end
                end
                S_REWIND: begin
                    cnt   <= '0;
                    state <= (off_q == '0) ? S_GET_HI : S_SKIP;
                end
                S_SKIP: if (take) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == off_q - 1'b1) state <= S_GET_HI;
                end
                S_GET_HI: if (take) begin
                    cnt   <= cnt + 1'b1;
                    state <= S_GET_LO;
                end
                S_GET_LO: if (take) begin
                    cnt   <= cnt + 1'b1;
                    state <= S_WAIT_TX;
                end
                S_WAIT_TX: begin
                    poll <= poll;
                    if (tick) begin
                        if (stat_txready) state <= S_WRITE;
                        else              poll  <= poll + 1'b1;
                    end
                end
                S_WRITE: state <= S_CHK_INIT;
                S_CHK_INIT: if (stat_init) state <= (cnt == len_q) ? S_WAIT_DONE : S_GET_HI;
                S_WAIT_DONE: begin
                    poll <= poll;
                    if (tick) begin
                        if (fpga_done) begin
                            fin_q <= 1'b1;
                            state <= S_RST;
                        end else poll <= poll + 1'b1;
                    end
                end
                default: if (!is_pulse) state <= S_IDLE;
            endcase
            if (att_fail) begin
                poll <= '0;
                if (tries == RW'(MAX_TRIES - 1)) begin
                    err_q <= att_code;
                    state <= S_FAIL;
                end else begin
                    tries <= tries + 1'b1;
                    fin_q <= 1'b0;
                    state <= S_RST;
                end
            end
        end
    end

    // Output decode from the sequencer state.
    always_comb begin
        cfg_wr        = (state == S_WRITE);
        bus_reset     = (state == S_RST);
        eeprom_reload = (state == S_RLD_HI);
        prog_pulse    = (state == S_PROG_HI);
        src_rewind    = (state == S_BEGIN) || (state == S_REWIND);
        busy          = !(state inside {S_IDLE, S_PASS, S_FAIL});
        done          = (state == S_PASS);
        error         = (state == S_FAIL);
        err_code      = err_q;
    end
endmodule

// File: rtl/bitload_ctrl_chk.sv
// Port-level checker for the bitstream loader, bound to every instance.
// Assumes synchronous active-low reset and flags stable at clock edges.
module bitload_ctrl_chk #(
    parameter int PULSE_CYC = 1000,
    parameter int MAX_TRIES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic [2:0] err_code,
    input logic       in_ready,
    input logic       cfg_wr,
    input logic       stat_txready,
    input logic       bus_reset,
    input logic       eeprom_reload,
    input logic       prog_pulse
);
    logic [7:0]  prog_cnt;
    logic [31:0] prog_run;
    logic        prog_d;

    // Count program pulses per load and measure the current pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_cnt <= '0;
            prog_run <= '0;
            prog_d   <= 1'b0;
        end else begin
            prog_d   <= prog_pulse;
            prog_run <= prog_pulse ? prog_run + 1 : '0;
            if (!busy)                     prog_cnt <= '0;
            else if (prog_pulse && !prog_d) prog_cnt <= prog_cnt + 1'b1;
        end
    end

    p_strobes_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_reset, eeprom_reload, prog_pulse, cfg_wr}));
    p_prog_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_run <= 32'(PULSE_CYC));
    p_wr_after_txready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> $past(stat_txready));
    p_attempt_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_cnt <= 8'(MAX_TRIES));
    p_result_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    p_ready_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);
    p_pass_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 3'd0));
    p_fail_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != 3'd0));
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(cfg_wr || bus_reset || eeprom_reload || prog_pulse));
endmodule

bind bitload_ctrl bitload_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
    .err_code(err_code), .in_ready(in_ready), .cfg_wr(cfg_wr),
    .stat_txready(stat_txready), .bus_reset(bus_reset),
    .eeprom_reload(eeprom_reload), .prog_pulse(prog_pulse)
);

// File: tb/tb_bitload_ctrl.sv
// Self-checking bench: a device and source model on the falling edge, with
// directed corner cases followed by seeded random streams.
module tb_bitload_ctrl;
    localparam int LW = 12;
    localparam int PULSE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] total_len = '0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready, src_rewind, cfg_wr, bus_reset, eeprom_reload, prog_pulse;
    logic          eeprom_present = 1'b1, stat_init = 1'b0, stat_txready = 1'b0, fpga_done = 1'b0;
    logic [15:0]   cfg_data;
    logic          busy, done, error;
    logic [2:0]    err_code;

    always #2.5 clk = ~clk;

    bitload_ctrl #(.LEN_W(LW), .POLL_DIV(2), .PULSE_CYC(PULSE), .INIT_POLLS(50),
                   .TXRDY_POLLS(100), .DONE_POLLS(200), .MAX_TRIES(3)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .src_rewind(src_rewind), .eeprom_present(eeprom_present),
        .stat_init(stat_init), .stat_txready(stat_txready), .fpga_done(fpga_done),
        .cfg_data(cfg_data), .cfg_wr(cfg_wr), .bus_reset(bus_reset),
        .eeprom_reload(eeprom_reload), .prog_pulse(prog_pulse), .busy(busy),
        .done(done), .error(error), .err_code(err_code));

    int          tests = 0, fails = 0;
    logic [7:0]  mem [64];
    logic [15:0] got [40];
    int          got_n, att, rew, ptr, cur_len, exp_n, last_pw, pw;
    int          fail_tries = 0, fail_kind = 0;
    longint      seq;
    bit          prev_acc = 0, p_rst = 0, p_rld = 0, p_prog = 0, p_rew = 0, failing;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int find_off(input int len);
        for (int i = 0; i + 1 < len; i++)
            if (mem[i] == 8'hFF && mem[i+1] == 8'h20) return i;
        return -1;
    endfunction

    function automatic int exp_code(input int len);
        int off = find_off(len);
        if (off < 0) return 1;
        if (((len - off) % 2) != 0) return 2;
        if (!eeprom_present) return 3;
        if (fail_tries >= 3) return fail_kind + 3;
        return 0;
    endfunction

    // Device and firmware-source model, acting between rising edges.
    initial begin : model
        forever begin
            @(negedge clk);
            if (prev_acc) ptr++;
            if (src_rewind) ptr = 0;
            in_data  = (ptr < 64) ? mem[ptr] : 8'h00;
            in_valid = (ptr < cur_len) && ($urandom % 3 != 0);
            prev_acc = in_valid && in_ready;
            if (bus_reset && !p_rst) seq = seq * 10 + 1;
            if (eeprom_reload && !p_rld) seq = seq * 10 + 2;
            if (prog_pulse && !p_prog) begin
                seq = seq * 10 + 3; att++; stat_init = 0; fpga_done = 0; got_n = 0; pw = 0;
            end
            if (prog_pulse) pw++;
            failing = (att > 0) && (att - 1 < fail_tries);
            if (!prog_pulse && p_prog) begin
                last_pw = pw;
                if (!(failing && fail_kind == 1)) stat_init = 1;
            end
            if (src_rewind && !p_rew) rew++;
            if (cfg_wr) begin
                if (got_n < 40) got[got_n] = cfg_data;
                got_n++;
                if (failing && fail_kind == 3 && got_n == 2) stat_init = 0;
                if (got_n == exp_n && !(failing && fail_kind == 4)) fpga_done = 1;
            end
            stat_txready = (failing && fail_kind == 2) ? 1'b0 : ($urandom % 4 != 0);
            p_rst = bus_reset; p_rld = eeprom_reload; p_prog = prog_pulse; p_rew = src_rewind;
        end
    end

    // Run one load and compare every observable result with the bench model.
    task automatic do_load(input int len, input string rq, input bit extra_start);
        int off, ec, n_att, n_init;
        longint eseq;
        off = find_off(len);
        ec  = exp_code(len);
        exp_n = (off >= 0) ? (len - off) / 2 : 0;
        cur_len = len; total_len = LW'(len);
        seq = 0; att = 0; rew = 0; got_n = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        if (extra_start) begin
            repeat (30) @(negedge clk);
            chk(busy == 1, "R11", "busy during load", busy, 1);
            start = 1; @(negedge clk); start = 0;
        end
        while (!(done || error)) @(negedge clk);
        @(negedge clk);
        chk(err_code == 3'(ec), rq, "err_code", err_code, ec);
        chk(done == (ec == 0) && error == (ec != 0), "R11", "done/error", {done, error}, ec == 0 ? 2 : 1);
        n_att = (ec >= 1 && ec <= 3) ? 0 : (ec == 0 ? fail_tries + 1 : 3);
        chk(att == n_att, "R10", "attempt count", att, n_att);
        eseq = 0;
        for (int a = 0; a < n_att; a++) eseq = eseq * 1000 + 123;
        if (ec == 0) eseq = eseq * 100 + 12;
        chk(seq == eseq, "R6", "pulse order", seq, eseq);
        n_init = n_att - ((fail_kind == 1) ? ((fail_tries < n_att) ? fail_tries : n_att) : 0);
        chk(rew == 1 + n_init, "R10", "rewind count", rew, 1 + n_init);
        if (ec == 0) begin
            chk(got_n == exp_n, "R5", "word count", got_n, exp_n);
            chk(got[0] == 16'hFF20, "R1", "first word", got[0], 16'hFF20);
            for (int j = 0; j < exp_n && j < 40; j++)
                chk(got[j] == {mem[off + 2*j], mem[off + 2*j + 1]}, "R5", "word value",
                    got[j], {mem[off + 2*j], mem[off + 2*j + 1]});
            chk(last_pw == PULSE, "R6", "program pulse width", last_pw, PULSE);
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !error && !in_ready && !cfg_wr && err_code == 0,
            "R11", "reset state", {busy, done, error, in_ready, cfg_wr}, 0);

        // R1: header with a lone 0xFF ahead of the pattern
        fill(20); mem[0]=8'h12; mem[1]=8'hFF; mem[2]=8'h34; mem[3]=8'hFF; mem[4]=8'h20;
        do_load(19, "R1", 0);
        // R1: pattern at byte 0
        fill(10); mem[0]=8'hFF; mem[1]=8'h20; do_load(10, "R1", 0);
        // R1: repeated 0xFF before the pattern
        fill(7); mem[0]=8'hFF; mem[1]=8'hFF; mem[2]=8'h20; do_load(7, "R1", 0);
        // R1: pattern in the last two bytes, one word
        mem[0]=8'h00; mem[1]=8'hFF; mem[2]=8'h20; do_load(3, "R1", 0);
        // R2: no pattern, and a too-short stream
        mem[0]=8'hFF; mem[1]=8'h00; mem[2]=8'h20; mem[3]=8'hFF; do_load(4, "R2", 0);
        do_load(1, "R2", 0);
        // R3: odd remaining length
        fill(6); mem[0]=8'hAA; mem[1]=8'hFF; mem[2]=8'h20; do_load(6, "R3", 0);
        // R4: configuration memory absent
        fill(8); mem[0]=8'hFF; mem[1]=8'h20; eeprom_present = 0;
        do_load(8, "R4", 0);
        eeprom_present = 1;
        // R6, R7, R8, R9: every attempt fails in one way
        fill(12); mem[2]=8'hFF; mem[3]=8'h20; mem[0]=8'h01; mem[1]=8'h02;
        fail_tries = 3;
        fail_kind = 1; do_load(12, "R6", 0);
        fail_kind = 2; do_load(12, "R7", 0);
        fail_kind = 3; do_load(12, "R8", 0);
        fail_kind = 4; do_load(12, "R9", 0);
        // R10: two failed attempts then a pass
        fail_tries = 2; fail_kind = 3; do_load(12, "R10", 0);
        fail_tries = 0; fail_kind = 0;
        // R11: a second start while busy is ignored
        do_load(12, "R11", 1);

        // Random streams with random recoverable failures (R1, R5, R10)
        for (int t = 0; t < 8; t++) begin
            int h, b;
            h = $urandom % 10; b = 2 + 2 * ($urandom % 12);
            fill(h + 2 + b);
            for (int i = 0; i < h; i++) if (mem[i] == 8'hFF) mem[i] = 8'h11;
            mem[h] = 8'hFF; mem[h+1] = 8'h20;
            fail_tries = $urandom % 3; fail_kind = 1 + $urandom % 4;
            do_load(h + 2 + b, "R10", 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule